// File: doc/BRIEF.md
# NAND Flash Byte Bus Sequencer

This block sits between a simple request port and an 8-bit asynchronous NAND flash device. It generates the chip enable, read strobe, write strobe, command latch and address latch pins. It also provides a split data bus (output value, output enable, input value). A single request starts one of eight operations:

- a control-line update, with an optional command or address byte;
- a write burst;
- a read burst;
- a read-and-compare verify burst;
- chip select;
- chip deselect;
- a ready/busy status query;
- a fixed settling wait.

Payload bytes enter through a valid/ready write stream. Read bytes leave through a valid/ready read stream. The verify operation takes its expected bytes from the write stream.

The pins are shared with other functions of the chip. For that reason, select and deselect hand them over in a fixed order and drive a sideband latch-enable output. All strobe timing is given as clock-cycle counts: setup before the strobe, strobe low width, hold after it, and the sample point inside a read strobe. The block reports `busy` while an operation runs. It pulses `done` once, together with the result flags, when the operation ends.

Top module: `nfseq_top`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_re_n` and `nand_we_n` are 1. `nand_cle`, `nand_ale`, `nand_dq_oe`, `pins_claimed` and `busy` are 0. `latch_en` is 1.
- R2: `nand_dq_oe` is 1 only during the byte cycles of a write burst or of a control command byte. It is never 1 while `nand_re_n` is 0. It drops after the hold time of the final byte.
- R3: A write burst (`req_op`=1) of N bytes gives exactly N low pulses of `nand_we_n`. Byte i of the write stream is on `nand_dq_out`, unchanged, for the whole of pulse i.
- R4: A read burst (`req_op`=2) of N bytes gives exactly N low pulses of `nand_re_n`. Each sampled `nand_dq_in` byte is delivered in order on the read stream. `nand_re_n` and `nand_we_n` are never low together.
- R5: Verify (`req_op`=3) compares each sampled byte with the next write-stream byte. It stops after the first mismatching byte, with `result_err`=1 beside `done`. When all N bytes match it ends with `result_err`=0 after N strobes.
- R6: `nand_cle` and `nand_ale` change only on a control request (`req_op`=0), which loads them from `req_cle` and `req_ale`. When `req_cmd_en`=1, `req_byte` is then written with a single `nand_we_n` pulse, while the new latch levels are already present. These levels stay stable during every `nand_we_n` pulse.
- R7: Select (`req_op`=4) changes the pins one clock apart, in this order: `latch_en` falls, `pins_claimed` rises (data and ready lines are inputs), then `nand_ce_n` falls. The read and write strobes stay high throughout. `nand_ce_n` is never low while `latch_en` is 1 or `pins_claimed` is 0.
- R8: Deselect (`req_op`=5) changes the pins one clock apart, in this order: `nand_ce_n` rises, `pins_claimed` falls, then `latch_en` rises.
- R9: Status (`req_op`=6) returns the level of `nand_rb`, where 1 means ready, on `result_rdy` with `done`. Wait (`req_op`=7) keeps `busy` high for WAIT_US × CLK_MHZ cycles, which is 5000 with the defaults.
- R10: `busy` is 1 from the clock after a request is accepted until `done`. A request presented while `busy` is 1 is ignored. A request presented in the `done` cycle is accepted. Strobes are high whenever `busy` is 0.
- R11: A burst request with `req_count`=0 raises `done` in the next cycle, with `busy` staying 0 and no strobe pulse.
- R12: Each byte cycle uses T_SETUP cycles of strobe-high setup, T_PULSE cycles of strobe low and T_HOLD cycles of hold. Each value is clamped to at least 1. A read samples at cycle T_SAMPLE of the low pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code (0 ctrl, 1 write, 2 read, 3 verify, 4 select, 5 deselect, 6 status, 7 wait) |
| req_cle | input | 1 | Command latch level for a control request |
| req_ale | input | 1 | Address latch level for a control request |
| req_cmd_en | input | 1 | Control request also writes `req_byte` |
| req_byte | input | 8 | Command or address byte |
| req_count | input | CNT_W | Burst length in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_err | output | 1 | Verify mismatch, valid with `done` |
| result_rdy | output | 1 | Sampled ready level, valid with `done` after a status request |
| wr_valid | input | 1 | Write/expected byte available |
| wr_data | input | 8 | Write/expected byte |
| wr_ready | output | 1 | Block takes the byte |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Consumer takes the read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy level, 1 = ready |
| pins_claimed | output | 1 | Shared data and ready pins are held as inputs for the flash |
| latch_en | output | 1 | Sideband latch enable for the shared pins |

## Verification
The sensitive overlap is a new request that arrives in the same cycle as the completion of the previous operation. The `done` pulse and the acceptance of the next request then fall on one clock edge. The bench provokes this by waiting for `done` and presenting a status request in that cycle. It expects a second `done` that carries the ready level of that moment. As a contrast, a one-cycle deselect request is injected in the middle of a write burst. The bench then checks that chip enable, the latch enable and the write pulse count are unchanged.

// File: rtl/nfseq_pkg.sv
`timescale 1ns/1ps
package nfseq_pkg;

  typedef enum logic [2:0] {
    OP_CTRL   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_READ   = 3'd2,
    OP_VERIFY = 3'd3,
    OP_SELECT = 3'd4,
    OP_DESEL  = 3'd5,
    OP_STATUS = 3'd6,
    OP_WAIT   = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_SETUP,
    S_PULSE,
    S_HOLD,
    S_PUSH,
    S_SEL_CLAIM,
    S_SEL_CE,
    S_DSEL_PINS,
    S_DSEL_LATCH,
    S_WAIT
  } st_e;

  // every timing count is at least one cycle
  function automatic int unsigned clamp1(input int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // remaining-count value of the pulse timer at which a read is sampled;
  // pos counts from 1 at the first low cycle and is limited to the pulse width
  function automatic int unsigned sample_remain(input int unsigned pulse, input int unsigned pos);
    int unsigned p;
    p = clamp1(pos);
    if (p > pulse) p = pulse;
    return pulse - p + 1;
  endfunction

  function automatic int unsigned wait_cycles(input int unsigned us, input int unsigned mhz);
    return clamp1(us * mhz);
  endfunction

  function automatic logic is_write_like(input op_e op);
    return (op == OP_CTRL) || (op == OP_WRITE);
  endfunction

  function automatic logic is_read_like(input op_e op);
    return (op == OP_READ) || (op == OP_VERIFY);
  endfunction

endpackage

// File: rtl/nfseq_phase_timer.sv
`timescale 1ns/1ps
module nfseq_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] remain,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign remain = cnt_q;
  assign last   = (cnt_q == W'(1));
endmodule

// File: rtl/nfseq_byte_counter.sv
`timescale 1ns/1ps
module nfseq_byte_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       left_q <= '0;
    else if (load)                    left_q <= load_val;
    else if (dec && left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign last = (left_q == W'(1));
endmodule

// File: rtl/nfseq_capture.sv
`timescale 1ns/1ps
module nfseq_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic [7:0] din,
  input  logic [7:0] expect_byte,
  output logic [7:0] byte_q,
  output logic       mismatch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (sample) byte_q <= din;
  end

  assign mismatch = (byte_q != expect_byte);
endmodule

// File: rtl/nfseq_top.sv
`timescale 1ns/1ps
module nfseq_top
  import nfseq_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned T_SETUP  = 2,
  parameter int unsigned T_PULSE  = 2,
  parameter int unsigned T_HOLD   = 1,
  parameter int unsigned T_SAMPLE = 2,
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned WAIT_US  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic             req_cle,
  input  logic             req_ale,
  input  logic             req_cmd_en,
  input  logic [7:0]       req_byte,
  input  logic [CNT_W-1:0] req_count,
  output logic             busy,
  output logic             done,
  output logic             result_err,
  output logic             result_rdy,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             nand_ce_n,
  output logic             nand_re_n,
  output logic             nand_we_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb,
  output logic             pins_claimed,
  output logic             latch_en
);
  localparam int unsigned SETUP_L = clamp1(T_SETUP);
  localparam int unsigned PULSE_L = clamp1(T_PULSE);
  localparam int unsigned HOLD_L  = clamp1(T_HOLD);
  localparam int unsigned WAIT_L  = wait_cycles(WAIT_US, CLK_MHZ);
  localparam int unsigned SAMP_R  = sample_remain(PULSE_L, T_SAMPLE);
  localparam int unsigned MAX_L   = max2(max2(SETUP_L, PULSE_L), max2(HOLD_L, WAIT_L));
  localparam int unsigned TW      = $clog2(MAX_L + 1);

  localparam logic [TW-1:0] SETUP_V = TW'(SETUP_L);
  localparam logic [TW-1:0] PULSE_V = TW'(PULSE_L);
  localparam logic [TW-1:0] HOLD_V  = TW'(HOLD_L);
  localparam logic [TW-1:0] WAIT_V  = TW'(WAIT_L);
  localparam logic [TW-1:0] SAMP_V  = TW'(SAMP_R);

  st_e  st_q, st_n;
  op_e  op_q;
  op_e  req_op_e;
  logic [7:0] data_q;
  logic cle_q, ale_q, ce_n_q, claim_q, latch_q;
  logic done_q, err_q, rdy_q;

  logic          t_ld;
  logic [TW-1:0] t_val;
  logic [TW-1:0] t_rem;
  logic          t_last;
  logic          b_dec, b_last;
  logic          done_n, err_n;
  logic          take_wr;
  logic [7:0]    cap_byte;
  logic          cap_mism;

  // named internal events
  logic ev_accept;
  logic ev_zero;
  logic ev_sample;
  logic wr_phase;
  logic rd_phase;

  assign req_op_e  = op_e'(req_op);
  assign ev_accept = (st_q == S_IDLE) && req_valid;
  assign ev_zero   = ev_accept && (req_count == '0) &&
                     ((req_op_e == OP_WRITE) || is_read_like(req_op_e));
  assign wr_phase  = is_write_like(op_q);
  assign rd_phase  = is_read_like(op_q);
  assign ev_sample = (st_q == S_PULSE) && rd_phase && (t_rem == SAMP_V);

  nfseq_phase_timer #(.W(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_ld), .load_val(t_val),
    .remain(t_rem), .last(t_last)
  );

  nfseq_byte_counter #(.W(CNT_W)) i_bytes (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .load_val(req_count),
    .dec(b_dec), .last(b_last)
  );

  nfseq_capture i_cap (
    .clk(clk), .rst_n(rst_n), .sample(ev_sample), .din(nand_dq_in),
    .expect_byte(data_q), .byte_q(cap_byte), .mismatch(cap_mism)
  );

  always_comb begin
    st_n    = st_q;
    t_ld    = 1'b0;
    t_val   = '0;
    b_dec   = 1'b0;
    done_n  = 1'b0;
    err_n   = 1'b0;
    take_wr = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        case (req_op_e)
          OP_CTRL: begin
            if (req_cmd_en) begin
              st_n = S_SETUP; t_ld = 1'b1; t_val = SETUP_V;
            end else begin
              done_n = 1'b1;
            end
          end
          OP_WRITE, OP_VERIFY: begin
            if (req_count == '0) done_n = 1'b1;
            else                 st_n = S_FETCH;
          end
          OP_READ: begin
            if (req_count == '0) done_n = 1'b1;
            else begin
              st_n = S_SETUP; t_ld = 1'b1; t_val = SETUP_V;
            end
          end
          OP_SELECT: st_n = S_SEL_CLAIM;
          OP_DESEL:  st_n = S_DSEL_PINS;
          OP_STATUS: done_n = 1'b1;
          OP_WAIT: begin
            st_n = S_WAIT; t_ld = 1'b1; t_val = WAIT_V;
          end
          default: done_n = 1'b1;
        endcase
      end
      S_FETCH: if (wr_valid) begin
        take_wr = 1'b1;
        st_n = S_SETUP; t_ld = 1'b1; t_val = SETUP_V;
      end
      S_SETUP: if (t_last) begin
        st_n = S_PULSE; t_ld = 1'b1; t_val = PULSE_V;
      end
      S_PULSE: if (t_last) begin
        st_n = S_HOLD; t_ld = 1'b1; t_val = HOLD_V;
      end
      S_HOLD: if (t_last) begin
        case (op_q)
          OP_READ: st_n = S_PUSH;
          OP_VERIFY: begin
            b_dec = 1'b1;
            if (cap_mism) begin
              done_n = 1'b1; err_n = 1'b1; st_n = S_IDLE;
            end else if (b_last) begin
              done_n = 1'b1; st_n = S_IDLE;
            end else begin
              st_n = S_FETCH;
            end
          end
          OP_WRITE: begin
            b_dec = 1'b1;
            if (b_last) begin done_n = 1'b1; st_n = S_IDLE; end
            else        st_n = S_FETCH;
          end
          default: begin
            done_n = 1'b1; st_n = S_IDLE;
          end
        endcase
      end
      S_PUSH: if (rd_ready) begin
        b_dec = 1'b1;
        if (b_last) begin
          done_n = 1'b1; st_n = S_IDLE;
        end else begin
          st_n = S_SETUP; t_ld = 1'b1; t_val = SETUP_V;
        end
      end
      S_SEL_CLAIM:  st_n = S_SEL_CE;
      S_SEL_CE:     begin done_n = 1'b1; st_n = S_IDLE; end
      S_DSEL_PINS:  st_n = S_DSEL_LATCH;
      S_DSEL_LATCH: begin done_n = 1'b1; st_n = S_IDLE; end
      S_WAIT: if (t_last) begin done_n = 1'b1; st_n = S_IDLE; end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_STATUS;
      data_q  <= '0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      ce_n_q  <= 1'b1;
      claim_q <= 1'b0;
      latch_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      if (take_wr) data_q <= wr_data;
      if (ev_accept) begin
        op_q <= req_op_e;
        case (req_op_e)
          OP_CTRL: begin
            cle_q  <= req_cle;
            ale_q  <= req_ale;
            data_q <= req_byte;
          end
          OP_SELECT: latch_q <= 1'b0;
          OP_DESEL:  ce_n_q  <= 1'b1;
          OP_STATUS: rdy_q   <= nand_rb;
          default: ;
        endcase
      end
      // ordered pin handoff steps
      if (st_q == S_SEL_CLAIM)  claim_q <= 1'b1;
      if (st_q == S_SEL_CE)     ce_n_q  <= 1'b0;
      if (st_q == S_DSEL_PINS)  claim_q <= 1'b0;
      if (st_q == S_DSEL_LATCH) latch_q <= 1'b1;
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign done         = done_q;
  assign result_err   = err_q;
  assign result_rdy   = rdy_q;
  assign wr_ready     = (st_q == S_FETCH);
  assign rd_valid     = (st_q == S_PUSH);
  assign rd_data      = cap_byte;
  assign nand_ce_n    = ce_n_q;
  assign nand_cle     = cle_q;
  assign nand_ale     = ale_q;
  assign nand_we_n    = !((st_q == S_PULSE) && wr_phase);
  assign nand_re_n    = !((st_q == S_PULSE) && rd_phase);
  assign nand_dq_oe   = wr_phase &&
                        ((st_q == S_SETUP) || (st_q == S_PULSE) || (st_q == S_HOLD));
  assign nand_dq_out  = data_q;
  assign pins_claimed = claim_q;
  assign latch_en     = latch_q;
endmodule

// File: rtl/nfseq_checks.sv
`timescale 1ns/1ps
module nfseq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       nand_ce_n,
  input logic       nand_re_n,
  input logic       nand_we_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic [7:0] nand_dq_out,
  input logic       nand_dq_oe,
  input logic       pins_claimed,
  input logic       latch_en,
  input logic       ev_zero
);
  // R2
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);

  // R3
  wr_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R6
  latch_lines_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> ($stable(nand_cle) && $stable(nand_ale)));

  // R7
  select_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> (!latch_en && pins_claimed));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_dq_oe));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  zero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> (done && !busy));
endmodule

bind nfseq_top nfseq_checks i_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .nand_ce_n(nand_ce_n), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_dq_out(nand_dq_out),
  .nand_dq_oe(nand_dq_oe), .pins_claimed(pins_claimed), .latch_en(latch_en),
  .ev_zero(ev_zero)
);

// File: tb/test_nfseq_top.sv
`timescale 1ns/1ps
module test_nfseq_top;
  localparam int SETUP = 2, PULSE = 2, HOLD = 1, SAMPLE = 2;
  localparam int WAITC = 25 * 200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_cle = 0, req_ale = 0, req_cmd_en = 0;
  logic [2:0] req_op = 0;
  logic [7:0] req_byte = 0;
  logic [15:0] req_count = 0;
  logic busy, done, result_err, result_rdy;
  logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 0;
  logic [7:0] wr_data, rd_data;
  logic nand_ce_n, nand_re_n, nand_we_n, nand_cle, nand_ale, nand_dq_oe;
  logic [7:0] nand_dq_out, nand_dq_in;
  logic nand_rb = 1;
  logic pins_claimed, latch_en;

  nfseq_top #(.CNT_W(16), .T_SETUP(SETUP), .T_PULSE(PULSE), .T_HOLD(HOLD),
              .T_SAMPLE(SAMPLE), .CLK_MHZ(200), .WAIT_US(25)) i_nfseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_cle(req_cle), .req_ale(req_ale), .req_cmd_en(req_cmd_en),
    .req_byte(req_byte), .req_count(req_count), .busy(busy), .done(done),
    .result_err(result_err), .result_rdy(result_rdy), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready), .nand_ce_n(nand_ce_n),
    .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .pins_claimed(pins_claimed),
    .latch_en(latch_en)
  );

  int nchk = 0, nerr = 0;
  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model of the flash read data
  logic [7:0] rbase = 0;
  function automatic logic [7:0] rpat(input logic [7:0] b, input int i);
    return (b + 8'(i * 29)) ^ 8'h5a;
  endfunction

  // stream sources and sinks
  logic [7:0] src [64];
  logic [7:0] rbuf [64];
  int sidx = 0, rcnt = 0, ridx = 0;
  assign wr_data    = src[sidx[5:0]];
  assign nand_dq_in = rpat(rbase, ridx);

  always @(posedge clk) begin
    if (wr_valid && wr_ready) sidx <= sidx + 1;
    if (rd_valid && rd_ready) begin
      rbuf[rcnt[5:0]] <= rd_data;
      rcnt <= rcnt + 1;
    end
    wr_valid <= ($urandom_range(0, 3) != 0);
    rd_ready <= ($urandom_range(0, 3) != 0);
  end

  // pin monitor, sampled away from the active edge
  int cyc = 0, wcnt = 0, recnt = 0;
  int wlow = 0, rlow = 0, scnt = 0, hcnt = 0;
  logic in_hold = 0;
  logic p_we = 1, p_re = 1, p_oe = 0, p_ce = 1, p_claim = 0, p_latch = 1;
  logic [7:0] wbuf [64];
  logic cle_at_we = 0, ale_at_we = 0;
  int t_latch_f = 0, t_claim_r = 0, t_ce_f = 0;
  int t_ce_r = 0, t_claim_f = 0, t_latch_r = 0;
  int busy_cyc = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (busy) busy_cyc++;
    if (!nand_we_n && p_we) begin
      wbuf[wcnt[5:0]] = nand_dq_out;
      wcnt++;
      cle_at_we = nand_cle;
      ale_at_we = nand_ale;
      chk(scnt == SETUP, "R12 setup cycles", scnt, SETUP);
    end
    if (!nand_we_n) begin
      wlow++;
      chk(nand_dq_oe, "R2 drive during write strobe", nand_dq_oe, 1);
    end
    if (nand_we_n && !p_we) begin
      chk(wlow == PULSE, "R3 write pulse width", wlow, PULSE);
      wlow = 0; in_hold = 1; hcnt = 0;
    end
    if (!nand_dq_oe) scnt = 0;
    else if (nand_we_n && !in_hold) scnt++;
    if (in_hold && nand_dq_oe && nand_we_n) hcnt++;
    if (!nand_dq_oe && p_oe) begin
      if (in_hold) chk(hcnt == HOLD, "R12 hold cycles", hcnt, HOLD);
      in_hold = 0;
    end
    if (!nand_re_n) begin
      rlow++;
      chk(!nand_dq_oe, "R2 no drive during read strobe", nand_dq_oe, 0);
    end
    if (!nand_re_n && p_re) recnt++;
    if (nand_re_n && !p_re) begin
      chk(rlow == PULSE, "R4 read pulse width", rlow, PULSE);
      rlow = 0;
      ridx++;
    end
    if (!latch_en && p_latch)     t_latch_f = cyc;
    if (latch_en && !p_latch)     t_latch_r = cyc;
    if (pins_claimed && !p_claim) t_claim_r = cyc;
    if (!pins_claimed && p_claim) t_claim_f = cyc;
    if (!nand_ce_n && p_ce)       t_ce_f = cyc;
    if (nand_ce_n && !p_ce)       t_ce_r = cyc;
    p_we = nand_we_n; p_re = nand_re_n; p_oe = nand_dq_oe;
    p_ce = nand_ce_n; p_claim = pins_claimed; p_latch = latch_en;
  end

  // requests: callers stand just after a rising edge
  task automatic start_req(input logic [2:0] op, input logic c, input logic a,
                           input logic ce, input logic [7:0] b, input int n);
    req_op = op; req_cle = c; req_ale = a; req_cmd_en = ce;
    req_byte = b; req_count = 16'(n); req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  logic got_err, got_rdy;
  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(posedge clk); #1; guard++;
    end
    got_err = result_err;
    got_rdy = result_rdy;
    chk(done, "R10 done reached", done, 1);
  endtask

  task automatic run(input logic [2:0] op, input logic c, input logic a,
                     input logic ce, input logic [7:0] b, input int n);
    start_req(op, c, a, ce, b, n);
    wait_done();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, w0, r0, k;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) src[i] = 8'(i);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(nand_ce_n && nand_re_n && nand_we_n, "R1 strobes high", {nand_ce_n, nand_re_n, nand_we_n}, 7);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches low", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(latch_en && !pins_claimed && !busy, "R1 handoff idle", {latch_en, pins_claimed, busy}, 4);
    rst_n = 1;
    @(posedge clk); #1;

    // R7 select
    run(3'd4, 0, 0, 0, 0, 0);
    chk(!nand_ce_n && !latch_en && pins_claimed, "R7 selected", {nand_ce_n, latch_en, pins_claimed}, 1);
    chk(t_claim_r == t_latch_f + 1, "R7 claim after latch", t_claim_r - t_latch_f, 1);
    chk(t_ce_f == t_claim_r + 1, "R7 ce after claim", t_ce_f - t_claim_r, 1);
    chk(wcnt == 0 && recnt == 0, "R7 no strobes", wcnt + recnt, 0);

    // R6 command byte with CLE
    w0 = wcnt;
    run(3'd0, 1, 0, 1, 8'h90, 0);
    chk(wcnt == w0 + 1, "R6 one pulse for command", wcnt - w0, 1);
    chk(wbuf[w0[5:0]] == 8'h90, "R6 command byte", wbuf[w0[5:0]], 8'h90);
    chk(cle_at_we && !ale_at_we, "R6 levels before strobe", {cle_at_we, ale_at_we}, 2);
    // R6 address byte with ALE
    w0 = wcnt;
    run(3'd0, 0, 1, 1, 8'h3c, 0);
    chk(wcnt == w0 + 1 && wbuf[w0[5:0]] == 8'h3c, "R6 address byte", wbuf[w0[5:0]], 8'h3c);
    chk(!cle_at_we && ale_at_we, "R6 ale level", {cle_at_we, ale_at_we}, 1);

    // R3 write bursts, random lengths and data
    for (int t = 0; t < 3; t++) begin
      n = $urandom_range(1, 12);
      for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
      sidx = 0; w0 = wcnt;
      run(3'd1, 0, 0, 0, 0, n);
      chk(wcnt == w0 + n, "R3 pulse count", wcnt - w0, n);
      for (int i = 0; i < n; i++)
        chk(wbuf[(w0 + i) % 64] == src[i], "R3 byte order", wbuf[(w0 + i) % 64], src[i]);
      chk(!nand_dq_oe, "R2 released after burst", nand_dq_oe, 0);
    end
    chk(!nand_cle && nand_ale, "R6 latches kept across burst", {nand_cle, nand_ale}, 1);
    w0 = wcnt;
    run(3'd0, 0, 0, 0, 0, 0);
    chk(!nand_cle && !nand_ale && wcnt == w0, "R6 clear without byte", {nand_cle, nand_ale, 1'b0} + wcnt - w0, 0);

    // R4 read bursts
    for (int t = 0; t < 3; t++) begin
      n = $urandom_range(1, 12);
      rbase = 8'($urandom); ridx = 0; rcnt = 0; r0 = recnt;
      run(3'd2, 0, 0, 0, 0, n);
      chk(recnt == r0 + n, "R4 read pulse count", recnt - r0, n);
      chk(rcnt == n, "R4 stream count", rcnt, n);
      for (int i = 0; i < n; i++)
        chk(rbuf[i] == rpat(rbase, i), "R4 read byte", rbuf[i], rpat(rbase, i));
    end

    // R5 verify, all matching
    n = 9; rbase = 8'h21; ridx = 0; sidx = 0; r0 = recnt;
    for (int i = 0; i < 64; i++) src[i] = rpat(rbase, i);
    run(3'd3, 0, 0, 0, 0, n);
    chk(!got_err, "R5 verify pass", got_err, 0);
    chk(recnt == r0 + n, "R5 strobes on pass", recnt - r0, n);
    // R5 verify, mismatch at index k
    k = 4; ridx = 0; sidx = 0; r0 = recnt;
    src[k] = ~src[k];
    run(3'd3, 0, 0, 0, 0, n);
    chk(got_err, "R5 verify mismatch", got_err, 1);
    chk(recnt == r0 + k + 1, "R5 stop at first mismatch", recnt - r0, k + 1);

    // R11 zero-length bursts
    for (int op = 1; op <= 3; op++) begin
      w0 = wcnt; r0 = recnt;
      start_req(3'(op), 0, 0, 0, 0, 0);
      chk(done && !busy, "R11 immediate done", {done, busy}, 2);
      chk(wcnt == w0 && recnt == r0, "R11 no strobes", wcnt - w0 + recnt - r0, 0);
      @(posedge clk); #1;
    end

    // R10 request during busy is ignored
    sidx = 0; w0 = wcnt;
    start_req(3'd1, 0, 0, 0, 0, 4);
    repeat (3) @(posedge clk);
    #1;
    chk(busy, "R10 busy during burst", busy, 1);
    start_req(3'd5, 0, 0, 0, 0, 0);
    wait_done();
    chk(wcnt == w0 + 4, "R10 burst unaffected", wcnt - w0, 4);
    chk(!nand_ce_n && !latch_en, "R10 deselect ignored", {nand_ce_n, latch_en}, 0);
    // R10 request in the done cycle is accepted (status, not ready)
    nand_rb = 0;
    start_req(3'd6, 0, 0, 0, 0, 0);
    wait_done();
    chk(!got_rdy, "R9 status busy level", got_rdy, 0);
    @(posedge clk); #1;
    nand_rb = 1;
    run(3'd6, 0, 0, 0, 0, 0);
    chk(got_rdy, "R9 status ready level", got_rdy, 1);

    // R9 fixed wait length
    busy_cyc = 0;
    run(3'd7, 0, 0, 0, 0, 0);
    chk(busy_cyc == WAITC, "R9 wait cycles", busy_cyc, WAITC);

    // R8 deselect order
    run(3'd5, 0, 0, 0, 0, 0);
    chk(nand_ce_n && latch_en && !pins_claimed, "R8 released", {nand_ce_n, latch_en, pins_claimed}, 6);
    chk(t_claim_f == t_ce_r + 1, "R8 pins after ce", t_claim_f - t_ce_r, 1);
    chk(t_latch_r == t_claim_f + 1, "R8 latch after pins", t_latch_r - t_claim_f, 1);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule